// File: doc/BRIEF.md
# Checksum-Based Way Predictor for a Four-Way Cache

This block narrows the search of a four-way set-associative second-level cache before any tag is read. For each way it keeps a one-byte checksum, plus a valid flag, for every set. The checksum of an address is the XOR of its three upper bytes. A lookup reads the four stored checksums of the request's set and compares each with the checksum of the request address. It returns a four-bit mask of the ways that could hold the line. A zero mask proves a miss, so the controller can skip the tag compare. A one-hot mask lets the controller read only one way.

The lookup can run in parallel with the first-level access. The mask is registered and is ready one cycle after the request. After a miss fill, the cache controller installs the checksum of the filled address into the chosen way through an update port. If an update and a lookup target the same set and way in the same cycle, the lookup sees the new contents.

Top module: `sig_way_predictor`

## Requirements
- R1: While reset is asserted, `maskValid` is 0 and `wayMask` is 0. Reset clears every stored valid flag, so any lookup after reset returns a zero mask.
- R2: An address's checksum is `addr[31:24] ^ addr[23:16] ^ addr[15:8]`. Its set index is `addr[13:4]`, which selects one of 1024 entries per way.
- R3: `maskValid` is high in exactly the cycle after a cycle with `lookupValid` high. `wayMask` is all zeros whenever `maskValid` is low.
- R4: Bit i of `wayMask` (bit 0 = way 0) is 1 exactly when way i's entry at the lookup set is valid and its checksum equals the lookup checksum.
- R5: No false negatives: after an address is installed in one or more ways, a lookup of that address sets every one of those ways' bits.
- R6: An update with `updValid` high writes the checksum of `updAddr` into entry `updAddr[13:4]` of way `updWay` only. A later update of the same entry replaces the old checksum, and no other way or set changes.
- R7: When an update and a lookup in the same cycle name the same set, the way being written reports the newly written checksum (write-first).
- R8: The prediction is by checksum only. A different address with the same set and the same checksum sets the bit, and an address in another set does not.
- R9: While `updValid` is low, `updWay` and `updAddr` have no effect on any stored entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| lookupValid | input | 1 | Lookup request this cycle |
| lookupAddr | input | 32 | Address to predict |
| updValid | input | 1 | Install a checksum this cycle |
| updWay | input | 2 | Way receiving the checksum |
| updAddr | input | 32 | Address whose checksum is installed |
| maskValid | output | 1 | Mask is valid this cycle |
| wayMask | output | 4 | Candidate-way mask, bit i = way i |

## Verification
The assertions assume that all inputs are driven to known values whenever reset is released. They also assume that `updWay` is always a legal way number while `updValid` is high. With four ways and a two-bit field, every code is legal. The bench changes inputs only on falling edges and holds every field at a defined value, including during idle cycles. This keeps the previous-cycle comparisons in the forwarding check well defined.

// File: rtl/sig_pred_pkg.sv
package sig_pred_pkg;
  localparam int ADDR_W    = 32;
  localparam int SIG_W     = 8;
  localparam int SIG_BYTES = 3;
  localparam int NUM_WAYS  = 4;
  localparam int WAY_W     = $clog2(NUM_WAYS);
  localparam int SET_LO    = 4;
  localparam int SET_BITS  = 10;
  localparam int NUM_SETS  = 1 << SET_BITS;
  localparam int SIG_LO    = ADDR_W - SIG_BYTES * SIG_W;

  typedef struct packed {
    logic [NUM_WAYS-1:0] wrWay;
    logic [NUM_WAYS-1:0] fwdWay;
    logic                capture;
  } ctlStrobes_t;

  function automatic logic [SIG_W-1:0] addrSig(input logic [ADDR_W-1:0] a);
    logic [SIG_W-1:0] s;
    s = '0;
    for (int k = 0; k < SIG_BYTES; k++) begin
      s = s ^ a[ADDR_W-1-k*SIG_W -: SIG_W];
    end
    return s;
  endfunction
endpackage

// File: rtl/sig_pred_ctrl.sv
module sig_pred_ctrl
  import sig_pred_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                lookupValid,
  input  logic [SET_BITS-1:0] lkSet,
  input  logic                updValid,
  input  logic [WAY_W-1:0]    updWay,
  input  logic [SET_BITS-1:0] updSet,
  output ctlStrobes_t         strb,
  output logic                maskValid
);
  logic sameSet;
  assign sameSet = lookupValid && updValid && (lkSet == updSet);

  // Decode the write strobe per way; a forward strobe accompanies it on a set collision.
  always_comb begin
    strb = '0;
    strb.capture = lookupValid;
    for (int w = 0; w < NUM_WAYS; w++) begin
      strb.wrWay[w]  = updValid && (updWay == WAY_W'(w));
      strb.fwdWay[w] = sameSet && (updWay == WAY_W'(w));
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) maskValid <= 1'b0;
    else       maskValid <= lookupValid;
  end
endmodule

// File: rtl/sig_pred_datapath.sv
module sig_pred_datapath
  import sig_pred_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  ctlStrobes_t         strb,
  input  logic [SET_BITS-1:0] lkSet,
  input  logic [SIG_W-1:0]    lkSig,
  input  logic [SET_BITS-1:0] updSet,
  input  logic [SIG_W-1:0]    updSig,
  output logic [NUM_WAYS-1:0] wayMask
);
  logic [NUM_WAYS-1:0] hitVec;

  for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way
    logic [SIG_W-1:0]    sigMem [NUM_SETS];
    logic [NUM_SETS-1:0] vldBits;
    logic [SIG_W-1:0]    rdSig;
    logic                rdVld;

    always_ff @(posedge clk) begin
      if (strb.wrWay[w]) sigMem[updSet] <= updSig;
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)              vldBits <= '0;
      else if (strb.wrWay[w]) vldBits[updSet] <= 1'b1;
    end

    assign rdSig = sigMem[lkSet];
    assign rdVld = vldBits[lkSet];

    // Write-first: a colliding update supplies the entry seen by the lookup.
    assign hitVec[w] = strb.fwdWay[w] ? (updSig == lkSig)
                                      : (rdVld && (rdSig == lkSig));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             wayMask <= '0;
    else if (strb.capture) wayMask <= hitVec;
    else                   wayMask <= '0;
  end
endmodule

// File: rtl/sig_way_predictor.sv
module sig_way_predictor
  import sig_pred_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                lookupValid,
  input  logic [ADDR_W-1:0]   lookupAddr,
  input  logic                updValid,
  input  logic [WAY_W-1:0]    updWay,
  input  logic [ADDR_W-1:0]   updAddr,
  output logic                maskValid,
  output logic [NUM_WAYS-1:0] wayMask
);
  logic [SET_BITS-1:0] lkSet, updSet;
  logic [SIG_W-1:0]    lkSig, updSig;
  ctlStrobes_t         strb;
  logic                unusedAddrLow;

  assign lkSet  = lookupAddr[SET_LO +: SET_BITS];
  assign updSet = updAddr[SET_LO +: SET_BITS];
  assign lkSig  = addrSig(lookupAddr);
  assign updSig = addrSig(updAddr);
  assign unusedAddrLow = ^{lookupAddr[SET_LO-1:0], updAddr[SET_LO-1:0]};

  sig_pred_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .lookupValid(lookupValid), .lkSet(lkSet),
    .updValid(updValid), .updWay(updWay), .updSet(updSet),
    .strb(strb), .maskValid(maskValid)
  );

  sig_pred_datapath u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .lkSet(lkSet), .lkSig(lkSig),
    .updSet(updSet), .updSig(updSig), .wayMask(wayMask)
  );
endmodule

// File: rtl/sig_pred_chk.sv
module sig_pred_chk
  import sig_pred_pkg::*;
(
  input logic                clk,
  input logic                rstN,
  input logic                lookupValid,
  input logic [ADDR_W-1:0]   lookupAddr,
  input logic                updValid,
  input logic [WAY_W-1:0]    updWay,
  input logic [ADDR_W-1:0]   updAddr,
  input logic                maskValid,
  input logic [NUM_WAYS-1:0] wayMask
);
  logic collideMatch;
  assign collideMatch = lookupValid && updValid &&
                        (lookupAddr[SET_LO +: SET_BITS] == updAddr[SET_LO +: SET_BITS]) &&
                        (addrSig(lookupAddr) == addrSig(updAddr));

  // R1
  always @(posedge clk) begin
    if (!rstN) begin
      reset_idle_chk: assert (!maskValid && wayMask == '0);
    end
  end

  // R3
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    lookupValid |=> maskValid);

  // R3
  valid_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    !lookupValid |=> !maskValid);

  // R3
  idle_mask_chk: assert property (@(posedge clk) disable iff (!rstN)
    !maskValid |-> (wayMask == '0));

  // R7
  fwd_hit_chk: assert property (@(posedge clk) disable iff (!rstN)
    collideMatch |=> wayMask[$past(updWay)]);
endmodule

bind sig_way_predictor sig_pred_chk u_chk (
  .clk(clk), .rstN(rstN), .lookupValid(lookupValid), .lookupAddr(lookupAddr),
  .updValid(updValid), .updWay(updWay), .updAddr(updAddr),
  .maskValid(maskValid), .wayMask(wayMask)
);

// File: tb/tb_sig_way_predictor.sv
module tb_sig_way_predictor;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        lookupValid = 1'b0;
  logic [31:0] lookupAddr = '0;
  logic        updValid = 1'b0;
  logic [1:0]  updWay = '0;
  logic [31:0] updAddr = '0;
  logic        maskValid;
  logic [3:0]  wayMask;

  int checks = 0;
  int errors = 0;

  // Addresses: A sig 0x70 set 0x167; B same set, same sig; C other set;
  // D same set, sig 0x71; E same set, sig 0x9D; F set 0x001, sig 0x00.
  localparam logic [31:0] ADR_A = 32'h1234_5670;
  localparam logic [31:0] ADR_B = 32'h3412_5670;
  localparam logic [31:0] ADR_C = 32'h1234_5770;
  localparam logic [31:0] ADR_D = 32'h1334_5670;
  localparam logic [31:0] ADR_E = 32'hFF34_5670;
  localparam logic [31:0] ADR_F = 32'h0000_0010;

  sig_way_predictor dut (
    .clk(clk), .rstN(rstN), .lookupValid(lookupValid), .lookupAddr(lookupAddr),
    .updValid(updValid), .updWay(updWay), .updAddr(updAddr),
    .maskValid(maskValid), .wayMask(wayMask)
  );

  always #(CLK_P/2) clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic install(input logic [1:0] way, input logic [31:0] a);
    @(negedge clk);
    updValid = 1'b1; updWay = way; updAddr = a;
    @(negedge clk);
    updValid = 1'b0;
  endtask

  task automatic lookup(input logic [31:0] a, output logic [3:0] m, output logic v);
    @(negedge clk);
    lookupValid = 1'b1; lookupAddr = a;
    @(posedge clk); #1;
    m = wayMask; v = maskValid;
    @(negedge clk);
    lookupValid = 1'b0;
  endtask

  task automatic testReset();
    logic [3:0] m; logic v;
    #1;
    chk("R1 reset maskValid", {31'b0, maskValid}, 32'd0);
    chk("R1 reset mask", {28'b0, wayMask}, 32'd0);
    @(negedge clk); rstN = 1'b1;
    lookup(ADR_A, m, v);
    chk("R1 empty lookup mask", {28'b0, m}, 32'd0);
    chk("R3 maskValid after lookup", {31'b0, v}, 32'd1);
  endtask

  task automatic testInstallAlias();
    logic [3:0] m; logic v;
    install(2'd2, ADR_A);
    lookup(ADR_A, m, v);
    chk("R5 installed way 2 hit", {28'b0, m}, 32'h4);
    lookup(ADR_B, m, v);
    chk("R8 alias same set same sig", {28'b0, m}, 32'h4);
    lookup(ADR_C, m, v);
    chk("R8 other set no hit", {28'b0, m}, 32'h0);
    lookup(ADR_D, m, v);
    chk("R2 R4 different checksum no hit", {28'b0, m}, 32'h0);
  endtask

  task automatic testMultiOverwrite();
    logic [3:0] m; logic v;
    install(2'd0, ADR_A);
    lookup(ADR_A, m, v);
    chk("R5 two ways hold A", {28'b0, m}, 32'h5);
    install(2'd2, ADR_E);
    lookup(ADR_A, m, v);
    chk("R6 overwrite way 2 drops A", {28'b0, m}, 32'h1);
    lookup(ADR_E, m, v);
    chk("R6 way 2 holds E", {28'b0, m}, 32'h4);
  endtask

  task automatic testIgnoredUpdate();
    logic [3:0] m; logic v;
    @(negedge clk);
    updValid = 1'b0; updWay = 2'd3; updAddr = ADR_A;
    @(negedge clk);
    updWay = 2'd0; updAddr = ADR_E;
    @(negedge clk);
    updAddr = '0;
    lookup(ADR_A, m, v);
    chk("R9 idle update leaves way 3 and way 0", {28'b0, m}, 32'h1);
    lookup(ADR_E, m, v);
    chk("R9 idle update leaves E only in way 2", {28'b0, m}, 32'h4);
  endtask

  task automatic testIsolation();
    logic [3:0] m; logic v;
    install(2'd1, ADR_F);
    lookup(ADR_F, m, v);
    chk("R6 way 1 set 1 hit", {28'b0, m}, 32'h2);
    lookup(ADR_A, m, v);
    chk("R6 set 0x167 unchanged", {28'b0, m}, 32'h1);
  endtask

  task automatic testForward();
    // State: way0=A, way2=E at set 0x167.
    @(negedge clk);
    updValid = 1'b1; updWay = 2'd3; updAddr = ADR_A;
    lookupValid = 1'b1; lookupAddr = ADR_A;
    @(posedge clk); #1;
    chk("R7 forward new entry way 3", {28'b0, wayMask}, 32'h9);
    @(negedge clk);
    updWay = 2'd0; updAddr = ADR_E;
    @(posedge clk); #1;
    chk("R7 forward overwrite way 0", {28'b0, wayMask}, 32'h8);
    @(negedge clk);
    updValid = 1'b0; lookupValid = 1'b0;
  endtask

  task automatic testLatency();
    // State: way0=E, way1=F(set 1), way2=E, way3=A.
    @(negedge clk);
    lookupValid = 1'b1; lookupAddr = ADR_A;
    @(posedge clk); #1;
    chk("R3 back-to-back first", {27'b0, maskValid, wayMask}, 32'h18);
    @(negedge clk);
    lookupAddr = ADR_F;
    @(posedge clk); #1;
    chk("R3 back-to-back second", {27'b0, maskValid, wayMask}, 32'h12);
    @(negedge clk);
    lookupValid = 1'b0;
    @(posedge clk); #1;
    chk("R3 idle drops maskValid and mask", {27'b0, maskValid, wayMask}, 32'h0);
  endtask

  task automatic testResetClears();
    logic [3:0] m; logic v;
    @(negedge clk); rstN = 1'b0;
    @(negedge clk); rstN = 1'b1;
    lookup(ADR_A, m, v);
    chk("R1 reset clears entries", {27'b0, v, m}, 32'h10);
  endtask

  initial begin
    #(CLK_P * 100000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    testReset();
    testInstallAlias();
    testMultiOverwrite();
    testIgnoredUpdate();
    testIsolation();
    testForward();
    testLatency();
    testResetClears();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule